// File: doc/BRIEF.md
# Filter Engine Instruction Sequencer

This block is the control sequencer of a filter compute engine. It steps a program counter through a small memory of 128-bit microinstructions and decodes each word as one of four operations. A wait operation parks the counter until an external sample-ready flag says enough input samples have arrived. A filter operation hands a command (filter type, decimation, taps minus one, clocks per calculation, and a decrement request with its value select) to the multiply-accumulate datapath. The sequencer then counts out the datapath's busy window. A jump operation reloads the counter. A no-op, or any unrecognised opcode, advances it by one.

A typical program is three words: wait, filter, jump back to the wait. This runs one filter pass per batch of input samples. Software loads the program through a valid/ready write port while the sequencer is disabled. The port drops ready whenever the sequencer is enabled, so a write is never accepted while the program runs. The filter command leaves on a valid/ready interface. While valid is high and ready is low, the command fields and the program counter hold still. The busy window begins only on the cycle after the handshake. The sample-ready flag, enable and busy are plain control pins.

Top module: `fseq_top`

## Requirements
- R1: After reset the program counter is 0, cmd_valid and busy are low, and every memory word holds a no-op, so an enabled sequencer with sample_rdy low steps the counter by one each clock.
- R2: wr_ready equals the inverse of en; a write presented while en is high is not stored and does not change program behaviour.
- R3: While en is low the program counter is held at 0 and cmd_valid stays low.
- R4: An instruction whose bits 7:0 are 80h, or any value other than 01h, 07h and C8h, advances the counter by one, wrapping from DEPTH-1 to 0.
- R5: An instruction with bits 7:0 equal to 01h holds the counter while sample_rdy is low and advances it by one on a clock where sample_rdy is high.
- R6: An instruction with bits 7:0 equal to 07h loads the counter from bits 16 upward (PC_W bits); the word 00000107h jumps to step 0.
- R7: An instruction with bits 7:0 equal to C8h raises cmd_valid with the fields: type from bits 11:8, decrement request bit 12, decrement select bit 13, decimation bits 41:32, taps minus one bits 57:48, clocks per calculation bits 73:64.
- R8: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and the counter and command fields do not change.
- R9: After a filter command handshake, busy is high for exactly N clocks (N is the clocks field, with 0 treated as 1), cmd_valid is low during that window, and the counter then advances by one.
- R10: A wait, filter, jump-to-0 program with sample_rdy and cmd_ready held high issues one filter command every N+3 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Sequencer enable; low holds the counter at 0 and opens the write port |
| wr_valid | input | 1 | Program write request |
| wr_ready | output | 1 | Program write accepted when high (only while disabled) |
| wr_addr | input | PC_W | Program word address |
| wr_data | input | 128 | Program word |
| sample_rdy | input | 1 | Enough input samples are available for one output |
| cmd_valid | output | 1 | Filter command present |
| cmd_ready | input | 1 | Datapath accepts the filter command |
| cmd_type | output | 4 | Filter type |
| cmd_dec_req | output | 1 | Request a wait-counter decrement |
| cmd_dec_sel | output | 1 | Which of two decrement values to apply |
| cmd_decim | output | 10 | Decimation |
| cmd_taps_m1 | output | 10 | Number of taps minus one |
| cmd_cycles | output | 10 | Clocks per calculation |
| busy | output | 1 | Datapath busy window after a command handshake |
| pc | output | PC_W | Current program counter |

## Verification
The assertions watch four behaviours on every cycle. While a command is stalled it stays valid and the counter does not move. A wait step with no sample ready keeps the counter still. Disabling returns the counter to 0. The end of every busy window advances the counter by exactly one. Only the bench's scenarios can show the opcode field positions and the exact busy length for a given clocks field, including the zero case. They also show that writes are refused while the sequencer is enabled, that the reset-time no-op fill makes the counter wrap, and the command rate of the full wait-filter-jump loop.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int INSTR_W = 128;
  localparam int OPC_W   = 8;

  localparam logic [OPC_W-1:0] OPC_WAIT = 8'h01;
  localparam logic [OPC_W-1:0] OPC_JUMP = 8'h07;
  localparam logic [OPC_W-1:0] OPC_NOP  = 8'h80;
  localparam logic [OPC_W-1:0] OPC_FIR  = 8'hC8;

  localparam logic [INSTR_W-1:0] NOP_WORD = {{(INSTR_W-OPC_W){1'b0}}, OPC_NOP};

  // field geometry of the filter instruction
  localparam int TYPE_LO  = 8;
  localparam int TYPE_W   = 4;
  localparam int DREQ_BIT = 12;
  localparam int DSEL_BIT = 13;
  localparam int DEC_LO   = 32;
  localparam int FLD_W    = 10;
  localparam int TAPS_LO  = 48;
  localparam int CYC_LO   = 64;
  localparam int TGT_LO   = 16;

  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_WAIT = 2'd1,
    OP_JUMP = 2'd2,
    OP_FIR  = 2'd3
  } op_e;

  typedef struct packed {
    logic [TYPE_W-1:0] ftype;
    logic              dec_req;
    logic              dec_sel;
    logic [FLD_W-1:0]  decim;
    logic [FLD_W-1:0]  taps_m1;
    logic [FLD_W-1:0]  cycles;
  } fir_cmd_t;
endpackage

// File: rtl/fseq_imem.sv
module fseq_imem
  import fseq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [INSTR_W-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output logic [INSTR_W-1:0] rdata
);
  logic [INSTR_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [INSTR_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= NOP_WORD;
      else if (we && (waddr == AW'(i)))
        word_q <= wdata;
    end
    assign words[i] = word_q;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [INSTR_W-1:0] instr,
  output op_e                op,
  output logic [AW-1:0]      jump_tgt,
  output fir_cmd_t           cmd
);
  logic [OPC_W-1:0] opc;
  assign opc = instr[OPC_W-1:0];

  always_comb begin
    unique case (opc)
      OPC_WAIT: op = OP_WAIT;
      OPC_JUMP: op = OP_JUMP;
      OPC_FIR:  op = OP_FIR;
      default:  op = OP_NOP;
    endcase
  end

  assign jump_tgt    = instr[TGT_LO +: AW];
  assign cmd.ftype   = instr[TYPE_LO +: TYPE_W];
  assign cmd.dec_req = instr[DREQ_BIT];
  assign cmd.dec_sel = instr[DSEL_BIT];
  assign cmd.decim   = instr[DEC_LO +: FLD_W];
  assign cmd.taps_m1 = instr[TAPS_LO +: FLD_W];
  assign cmd.cycles  = instr[CYC_LO +: FLD_W];
endmodule

// File: rtl/fseq_core.sv
module fseq_core
  import fseq_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sample_rdy,
  input  op_e              op,
  input  logic [AW-1:0]    jump_tgt,
  input  logic [FLD_W-1:0] cycles,
  input  logic             cmd_ready,
  output logic             cmd_valid,
  output logic             busy,
  output logic [AW-1:0]    pc
);
  typedef enum logic {S_RUN = 1'b0, S_BUSY = 1'b1} st_e;

  st_e              st_q;
  logic [AW-1:0]    pc_q;
  logic [FLD_W-1:0] cnt_q;
  logic [AW-1:0]    pc_inc;
  logic [FLD_W-1:0] load_cnt;

  assign pc_inc   = pc_q + 1'b1;
  assign load_cnt = (cycles == '0) ? FLD_W'(1) : cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_RUN;
      pc_q  <= '0;
      cnt_q <= '0;
    end else if (!en) begin
      st_q  <= S_RUN;
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        S_RUN: begin
          unique case (op)
            OP_WAIT: if (sample_rdy) pc_q <= pc_inc;
            OP_JUMP: pc_q <= jump_tgt;
            OP_FIR: begin
              if (cmd_ready) begin
                st_q  <= S_BUSY;
                cnt_q <= load_cnt;
              end
            end
            default: pc_q <= pc_inc;
          endcase
        end
        S_BUSY: begin
          if (cnt_q == FLD_W'(1)) begin
            st_q <= S_RUN;
            pc_q <= pc_inc;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= S_RUN;
      endcase
    end
  end

  assign cmd_valid = en && (st_q == S_RUN) && (op == OP_FIR);
  assign busy      = (st_q == S_BUSY);
  assign pc        = pc_q;

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd_valid && !cmd_ready) |=> (!en || (cmd_valid && $stable(pc))));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_q == S_RUN && op == OP_WAIT && !sample_rdy) |=> (!en || $stable(pc)));

  // R3
  dis_pc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pc == '0));

  // R9
  busy_end_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(en)) |-> (pc == AW'($past(pc) + 1'b1)));
endmodule

// File: rtl/fseq_top.sv
module fseq_top
  import fseq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PC_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [PC_W-1:0]    wr_addr,
  input  logic [INSTR_W-1:0] wr_data,
  input  logic               sample_rdy,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [TYPE_W-1:0]  cmd_type,
  output logic               cmd_dec_req,
  output logic               cmd_dec_sel,
  output logic [FLD_W-1:0]   cmd_decim,
  output logic [FLD_W-1:0]   cmd_taps_m1,
  output logic [FLD_W-1:0]   cmd_cycles,
  output logic               busy,
  output logic [PC_W-1:0]    pc
);
  logic [INSTR_W-1:0] instr;
  op_e                op;
  logic [PC_W-1:0]    jump_tgt;
  fir_cmd_t           cmd;
  logic               wr_fire;

  assign wr_ready = !en;
  assign wr_fire  = wr_valid && wr_ready;

  fseq_imem #(.DEPTH(DEPTH)) u_imem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (pc),
    .rdata (instr)
  );

  fseq_decode #(.AW(PC_W)) u_dec (
    .instr    (instr),
    .op       (op),
    .jump_tgt (jump_tgt),
    .cmd      (cmd)
  );

  fseq_core #(.AW(PC_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .sample_rdy (sample_rdy),
    .op         (op),
    .jump_tgt   (jump_tgt),
    .cycles     (cmd.cycles),
    .cmd_ready  (cmd_ready),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .pc         (pc)
  );

  assign cmd_type    = cmd.ftype;
  assign cmd_dec_req = cmd.dec_req;
  assign cmd_dec_sel = cmd.dec_sel;
  assign cmd_decim   = cmd.decim;
  assign cmd_taps_m1 = cmd.taps_m1;
  assign cmd_cycles  = cmd.cycles;
endmodule

// File: tb/fseq_top_tb.sv
module fseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [127:0] wr_data = '0;
  logic sample_rdy = 1'b0;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [3:0] cmd_type;
  logic cmd_dec_req, cmd_dec_sel;
  logic [9:0] cmd_decim, cmd_taps_m1, cmd_cycles;
  logic busy;
  logic [AW-1:0] pc;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fseq_top #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_rdy(sample_rdy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_type(cmd_type), .cmd_dec_req(cmd_dec_req), .cmd_dec_sel(cmd_dec_sel),
    .cmd_decim(cmd_decim), .cmd_taps_m1(cmd_taps_m1), .cmd_cycles(cmd_cycles),
    .busy(busy), .pc(pc)
  );

  typedef struct packed {
    logic [127:0] word;
    logic         exp_valid;
    logic [3:0]   exp_pc;
  } vec_t;

  // word at step 0, cmd_valid before the edge, pc after one edge (sample_rdy=1, cmd_ready=0)
  localparam vec_t VECS [6] = '{
    '{128'h80, 1'b0, 4'd1},                                    // R4 no-op
    '{128'h01, 1'b0, 4'd1},                                    // R5 wait, sample ready
    '{128'h0005_0007, 1'b0, 4'd5},                             // R6 jump to 5
    '{128'h107, 1'b0, 4'd0},                                   // R6 jump to 0
    '{128'h55, 1'b0, 4'd1},                                    // R4 undefined opcode
    '{128'h00000000_00000005_00090004_000015C8, 1'b1, 4'd0}    // R7 filter, stalled
  };

  function automatic logic [127:0] fir_word(input logic [3:0] t, input logic rq,
      input logic sl, input logic [9:0] d, input logic [9:0] tm, input logic [9:0] c);
    logic [127:0] w;
    w = 128'hC8;
    w[11:8] = t; w[12] = rq; w[13] = sl;
    w[41:32] = d; w[57:48] = tm; w[73:64] = c;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_word(input int a, input logic [127:0] d);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic disable_seq();
    en = 1'b0; step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hs;
    int bcount;
    #(CLK_PERIOD*2 + 1);
    // R1 reset state
    check(pc == 0, "R1 pc", pc, 0);
    check(!cmd_valid, "R1 cmd_valid", cmd_valid, 0);
    check(!busy, "R1 busy", busy, 0);
    check(wr_ready, "R2 wr_ready while disabled", wr_ready, 1);
    rst_n = 1'b1;
    step();

    // R1/R4: no-op fill, walk and wrap
    en = 1'b1;
    repeat (3) step();
    check(pc == 3, "R1 no-op fill walk", pc, 3);
    check(!wr_ready, "R2 wr_ready while enabled", wr_ready, 0);
    repeat (DEPTH) step();
    check(pc == 3, "R4 wrap", pc, 3);

    // table of single-instruction vectors
    for (int i = 0; i < 6; i++) begin
      disable_seq();
      write_word(0, VECS[i].word);
      sample_rdy = 1'b1; cmd_ready = 1'b0; en = 1'b1;
      #2;
      check(cmd_valid == VECS[i].exp_valid, "R7 vector cmd_valid", cmd_valid, VECS[i].exp_valid);
      step();
      check(pc == VECS[i].exp_pc, "R4 R5 R6 vector pc", pc, VECS[i].exp_pc);
      if (VECS[i].exp_valid) begin
        check(cmd_type == 5, "R7 type", cmd_type, 5);
        check(cmd_dec_req == 1 && cmd_dec_sel == 0, "R7 decrement bits",
              {cmd_dec_req, cmd_dec_sel}, 2);
        check(cmd_decim == 4, "R7 decimation", cmd_decim, 4);
        check(cmd_taps_m1 == 9, "R7 taps", cmd_taps_m1, 9);
        check(cmd_cycles == 5, "R7 cycles", cmd_cycles, 5);
      end
    end

    // R2: write while enabled is dropped
    disable_seq();
    write_word(0, 128'h80);
    write_word(1, 128'h80);
    en = 1'b1; sample_rdy = 1'b0;
    wr_valid = 1'b1; wr_addr = 1; wr_data = 128'h01;
    step();
    wr_valid = 1'b0;
    disable_seq();
    en = 1'b1;
    repeat (2) step();
    check(pc == 2, "R2 write ignored while enabled", pc, 2);

    // R3: disabled holds pc at 0
    en = 1'b0; sample_rdy = 1'b1;
    repeat (4) step();
    check(pc == 0, "R3 pc held", pc, 0);
    check(!cmd_valid, "R3 no command", cmd_valid, 0);

    // program: wait, filter(3 clocks), jump 0
    write_word(0, 128'h01);
    write_word(1, fir_word(4'd2, 1'b0, 1'b1, 10'd8, 10'd15, 10'd3));
    write_word(2, 128'h107);
    sample_rdy = 1'b0; cmd_ready = 1'b0; en = 1'b1;
    repeat (5) step();
    check(pc == 0, "R5 wait holds", pc, 0);
    sample_rdy = 1'b1; step(); sample_rdy = 1'b0;
    check(pc == 1 && cmd_valid, "R5 advance on sample_rdy", pc, 1);
    repeat (3) step();
    check(pc == 1 && cmd_valid && !busy, "R8 stalled command holds", pc, 1);
    check(cmd_decim == 8 && cmd_taps_m1 == 15, "R8 fields stable", cmd_decim, 8);
    cmd_ready = 1'b1; step(); cmd_ready = 1'b0;
    bcount = 0;
    while (busy && bcount < 20) begin
      check(!cmd_valid, "R9 no command during busy", cmd_valid, 0);
      bcount++; step();
    end
    check(bcount == 3, "R9 busy length", bcount, 3);
    check(pc == 2, "R9 advance after busy", pc, 2);
    step();
    check(pc == 0, "R6 loop back", pc, 0);

    // R10: steady loop rate
    disable_seq();
    sample_rdy = 1'b1; cmd_ready = 1'b1; en = 1'b1;
    hs = 0;
    for (int c = 0; c < 60; c++) begin
      if (cmd_valid && cmd_ready) hs++;
      step();
    end
    check(hs == 10, "R10 command rate", hs, 10);

    // R9: zero clocks field treated as one
    disable_seq();
    write_word(1, fir_word(4'd1, 1'b1, 1'b1, 10'd2, 10'd3, 10'd0));
    sample_rdy = 1'b1; cmd_ready = 1'b1; en = 1'b1;
    step(); step();
    bcount = 0;
    while (busy && bcount < 20) begin bcount++; step(); end
    check(bcount == 1, "R9 zero clocks busy length", bcount, 1);
    check(pc == 2, "R9 advance after one clock", pc, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule